// File: doc/BRIEF.md
# Watchdog Timer with Timed Reset Pulse

This block supervises software by counting time on the doubled oscillator clock. A 13-bit free-running prescaler, which other system timing also taps, advances once per clock. Each time it rolls over from all ones to zero it feeds one count into a watchdog counter. If software fails to service the watchdog before that counter has seen a set number of rollovers, the block drives its active-low reset output for a fixed 32 clocks and latches a cause flag that software can read after the restart.

Software services the watchdog with a write to the control location of a small register port. The data value of the write does not matter, so the port carries no write data. The write clears the watchdog counter and the upper part of the prescaler, bits 12 down to 5, and leaves bits 4 down to 0 alone. A read of the control location returns an externally supplied byte, the low byte of the restart vector. A read of the status location returns the cause flag and clears it. A stop-mode strobe zeroes the whole prescaler. A disable input, asserted in monitor mode, holds the watchdog counter cleared.

The control is a two-state machine. `ST_RUN` is the counting state. On transition `T_TIMEOUT`, taken when the counter expires, the machine enters `ST_PULSE`. There it holds the reset output low and holds the prescaler and counter at zero. On transition `T_RELEASE`, taken after the pulse counter has covered the pulse length, it returns to `ST_RUN`.

Top module: `wdt_top`

## Requirements
- R1: After `por_n` is low, `rst_out_n` is 1, `cause_flag` is 0 and `presc_q` is 0.
- R2: In `ST_RUN`, with no stop strobe and no control write, `presc_q` rises by one per clock and wraps from 8191 to 0.
- R3: Each prescaler wrap advances the watchdog counter. The edge of the CNT_LIMIT-th wrap since the counter was last cleared enters `ST_PULSE`, and `rst_out_n` is low right after that edge.
- R4: `rst_out_n` stays low for exactly PULSE_LEN (32) clocks. During that time `presc_q` and the counter are held at 0, so counting restarts from 0 after release.
- R5: Entering `ST_PULSE` sets `cause_flag`.
- R6: A read with `bus_addr`=1 returns `cause_flag` in bit 0 and zeros in bits 7:1. That clock edge clears `cause_flag`, unless a timeout occurs on the same edge.
- R7: A write with `bus_addr`=0, in `ST_RUN`, clears the counter and `presc_q[12:5]`, and leaves `presc_q[4:0]` unchanged on that edge.
- R8: A read with `bus_addr`=0 returns `vec_lo` on `bus_rdata`.
- R9: `stop_strobe` zeroes the whole prescaler and leaves the counter unchanged. When a stop strobe and a control write arrive together, the stop strobe decides the prescaler value and the write still clears the counter.
- R10: While `mon_disable` is 1, the counter is held at 0 and no timeout occurs. The prescaler keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe (data-less) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = control, 1 = status |
| bus_rdata | output | 8 | Read data |
| vec_lo | input | 8 | Restart vector low byte, returned on control reads |
| stop_strobe | input | 1 | Stop-mode entry, clears the prescaler |
| mon_disable | input | 1 | Monitor-mode watchdog disable |
| rst_out_n | output | 1 | Reset output, active low |
| cause_flag | output | 1 | Watchdog-caused reset flag |
| presc_q | output | 13 | Shared prescaler value |

## Verification
The bound checker watches several rules on every cycle. It checks the prescaler step, the partial clear on a service write, the full clear on a stop strobe, and the hold of the prescaler at zero while reset is low. It also checks the exact pulse length, that the cause flag is set when reset falls, that a status read clears the flag, and that no timeout occurs while the disable input is high. Other behaviour is only visible through the bench's scenarios. This covers the exact edge of a timeout after a given mix of services, stops and wraps, the fact that a stop leaves the counter value in place, the restart-vector read path, and the status readback.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_PULSE = 1'b1
    } wdt_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int W      = 13,
    parameter int CLR_LO = 5,
    parameter int CLR_HI = 12
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         hold,
    input  logic         stop_clr,
    input  logic         svc_clr,
    output logic [W-1:0] q,
    output logic         wrap
);
    localparam logic [W-1:0] SVC_MASK =
        W'(((64'd1 << (CLR_HI + 1)) - 64'd1) & ~((64'd1 << CLR_LO) - 64'd1));
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    assign wrap = !hold && !stop_clr && !svc_clr && (q == ALL_ONES);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                q <= '0;
        else if (hold || stop_clr) q <= '0;
        else if (svc_clr)          q <= q & ~SVC_MASK;
        else                       q <= q + 1'b1;
    end
endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic wrap,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = wrap && !clear && (cnt_q == LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (wrap) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int PRESC_W   = 13,
    parameter int CLR_LO    = 5,
    parameter int CLR_HI    = 12,
    parameter int CNT_LIMIT = 8,
    parameter int PULSE_LEN = 32
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr,
    output logic [7:0]         bus_rdata,
    input  logic [7:0]         vec_lo,
    input  logic               stop_strobe,
    input  logic               mon_disable,
    output logic               rst_out_n,
    output logic               cause_flag,
    output logic [PRESC_W-1:0] presc_q
);
    localparam int PCW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSE_LEN - 1);

    wdt_state_e     state_q, state_d;
    logic [PCW-1:0] pcnt_q;
    logic           hold, wr_ctl, rd_stat, svc, wrap, expire, pulse_done;

    assign hold       = (state_q == ST_PULSE);
    assign wr_ctl     = bus_sel && bus_wr && !bus_addr;
    assign rd_stat    = bus_sel && bus_rd && bus_addr;
    assign svc        = wr_ctl && !hold;
    assign pulse_done = (pcnt_q == PULSE_LAST);

    wdt_prescaler #(.W(PRESC_W), .CLR_LO(CLR_LO), .CLR_HI(CLR_HI)) u_presc (
        .clk      (clk),
        .por_n    (por_n),
        .hold     (hold),
        .stop_clr (stop_strobe),
        .svc_clr  (svc),
        .q        (presc_q),
        .wrap     (wrap)
    );

    wdt_timeout_cnt #(.LIMIT(CNT_LIMIT)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .clear  (hold || svc || mon_disable),
        .wrap   (wrap),
        .expire (expire)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: T_TIMEOUT and T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (expire)     state_d = ST_PULSE;
            ST_PULSE: if (pulse_done) state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // Pulse length counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     pcnt_q <= '0;
        else if (hold)  pcnt_q <= pcnt_q + 1'b1;
        else            pcnt_q <= '0;
    end

    // Cause flag: timeout sets, status read clears
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       cause_flag <= 1'b0;
        else if (expire)  cause_flag <= 1'b1;
        else if (rd_stat) cause_flag <= 1'b0;
    end

    // Outputs
    always_comb begin
        rst_out_n = (state_q != ST_PULSE);
        bus_rdata = 8'h00;
        if (bus_sel && bus_rd) begin
            if (bus_addr) bus_rdata = {7'b0, cause_flag};
            else          bus_rdata = vec_lo;
        end
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int PRESC_W   = 13,
    parameter int CLR_LO    = 5,
    parameter int CLR_HI    = 12,
    parameter int PULSE_LEN = 32
) (
    input logic               clk,
    input logic               por_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               bus_addr,
    input logic               stop_strobe,
    input logic               mon_disable,
    input logic               rst_out_n,
    input logic               cause_flag,
    input logic [PRESC_W-1:0] presc_q
);
    logic [7:0] low_run;
    logic       wr_c, rd_s;

    assign wr_c = bus_sel && bus_wr && !bus_addr;
    assign rd_s = bus_sel && bus_rd && bus_addr;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          low_run <= '0;
        else if (!rst_out_n) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    p_presc_step_r2: assert property (@(posedge clk) disable iff (!por_n)
        (rst_out_n && !stop_strobe && !wr_c) |=> presc_q == PRESC_W'($past(presc_q) + 1'b1));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> low_run == 8'(PULSE_LEN));

    p_pulse_bound_r4: assert property (@(posedge clk) disable iff (!por_n)
        low_run <= 8'(PULSE_LEN));

    p_pulse_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_out_n && $past(!rst_out_n)) |-> presc_q == '0);

    p_cause_set_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out_n) |-> cause_flag);

    p_cause_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
        rd_s |=> (!cause_flag || $fell(rst_out_n)));

    p_service_r7: assert property (@(posedge clk) disable iff (!por_n)
        (wr_c && rst_out_n && !stop_strobe) |=>
            (presc_q[CLR_HI:CLR_LO] == '0 &&
             presc_q[CLR_LO-1:0] == $past(presc_q[CLR_LO-1:0])));

    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
        stop_strobe |=> presc_q == '0);

    p_disable_r10: assert property (@(posedge clk) disable iff (!por_n)
        (mon_disable && rst_out_n) |=> rst_out_n);
endmodule

bind wdt_top wdt_checker #(
    .PRESC_W(PRESC_W), .CLR_LO(CLR_LO), .CLR_HI(CLR_HI), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .stop_strobe (stop_strobe),
    .mon_disable (mon_disable),
    .rst_out_n   (rst_out_n),
    .cause_flag  (cause_flag),
    .presc_q     (presc_q)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 4;
    localparam int WRAP       = 8192;
    localparam int PLEN       = 32;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  vec_lo = 8'h00;
    logic        stop_strobe = 1'b0, mon_disable = 1'b0;
    logic        rst_out_n, cause_flag;
    logic [12:0] presc_q;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    wdt_top #(.CNT_LIMIT(LIMIT), .PULSE_LEN(PLEN)) u_dut (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .vec_lo(vec_lo), .stop_strobe(stop_strobe), .mon_disable(mon_disable),
        .rst_out_n(rst_out_n), .cause_flag(cause_flag), .presc_q(presc_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: predicts the edge of the next timeout
    task automatic push_timeout(input int c, input int p, input int k);
        exp_q.push_back(c + (WRAP - p) + (LIMIT - 1 - k) * WRAP);
    endtask

    task automatic wait_release();
        @(posedge rst_out_n);
        @(negedge clk);
    endtask

    // Monitor: pops expected timeout edges and checks pulse shape
    logic prev_rst = 1'b1;
    int   fall_cyc = 0;
    always @(negedge clk) begin
        if (por_n) begin
            if (prev_rst && !rst_out_n) begin
                fall_cyc = cyc;
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected timeout", cyc, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R3 timeout edge", cyc, e);
                end
                chk(cause_flag == 1'b1, "R5 cause set", int'(cause_flag), 1);
            end
            if (!prev_rst && rst_out_n)
                chk(cyc - fall_cyc == PLEN, "R4 pulse length", cyc - fall_cyc, PLEN);
        end
        prev_rst = rst_out_n;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", cyc, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c, t, e;
        step(3);
        por_n = 1'b1;
        c = cyc;
        chk(rst_out_n == 1'b1, "R1 reset out high", int'(rst_out_n), 1);
        chk(cause_flag == 1'b0, "R1 cause clear", int'(cause_flag), 0);
        chk(presc_q == 13'd0, "R1 prescaler zero", int'(presc_q), 0);
        push_timeout(c, 0, 0);

        step(100);
        chk(presc_q == 13'd100, "R2 prescaler count", int'(presc_q), 100);
        bus_sel = 1; bus_rd = 1; bus_addr = 0; vec_lo = 8'hA5;
        #1 chk(bus_rdata == 8'hA5, "R8 vector read", int'(bus_rdata), 8'hA5);
        vec_lo = 8'h3C;
        #1 chk(bus_rdata == 8'h3C, "R8 vector read", int'(bus_rdata), 8'h3C);
        bus_addr = 1;
        #1 chk(bus_rdata == 8'h00, "R6 status before timeout", int'(bus_rdata), 0);
        bus_sel = 0; bus_rd = 0; bus_addr = 0;
        step(WRAP - 1 - 100);
        chk(presc_q == 13'd8191, "R2 prescaler top", int'(presc_q), 8191);
        step(1);
        chk(presc_q == 13'd0, "R2 prescaler wrap", int'(presc_q), 0);

        wait_release();
        e = cyc;
        chk(presc_q == 13'd0, "R4 restart from zero", int'(presc_q), 0);
        bus_sel = 1; bus_rd = 1; bus_addr = 1;
        #1 chk(bus_rdata == 8'h01, "R6 status read", int'(bus_rdata), 1);
        step(1);
        bus_sel = 0; bus_rd = 0; bus_addr = 0;
        chk(cause_flag == 1'b0, "R6 read clears cause", int'(cause_flag), 0);

        // Service with counter at 1
        t = e + WRAP + 13'h1234;
        step(t - cyc);
        chk(presc_q == 13'h1234, "R2 prescaler before service", int'(presc_q), 13'h1234);
        bus_sel = 1; bus_wr = 1; bus_addr = 0;
        step(1);
        bus_sel = 0; bus_wr = 0;
        chk(presc_q == 13'h0014, "R7 service partial clear", int'(presc_q), 13'h0014);
        push_timeout(cyc, 13'h0014, 0);

        wait_release();
        e = cyc;
        // Stop strobe with counter at 1
        t = e + WRAP + 300;
        step(t - cyc);
        stop_strobe = 1;
        step(1);
        stop_strobe = 0;
        chk(presc_q == 13'd0, "R9 stop clears prescaler", int'(presc_q), 0);
        push_timeout(cyc, 0, 1);

        wait_release();
        step(500);
        chk(presc_q == 13'd500, "R2 prescaler after release", int'(presc_q), 500);
        stop_strobe = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0;
        step(1);
        stop_strobe = 0; bus_sel = 0; bus_wr = 0;
        chk(presc_q == 13'd0, "R9 stop beats service", int'(presc_q), 0);
        c = cyc;
        mon_disable = 1;
        step(36000);
        chk(rst_out_n == 1'b1, "R10 no timeout while disabled", int'(rst_out_n), 1);
        chk(int'(presc_q) == (cyc - c) % WRAP, "R10 prescaler runs", int'(presc_q), (cyc - c) % WRAP);
        mon_disable = 0;
        step(2);
        chk(exp_q.size() == 0, "R3 all timeouts seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule